// File: doc/BRIEF.md
# Triggered Capture/Compare Counter Channel

This block is a single timer channel built around an up-counter (16 bits by default). Software-style control inputs load the count and the compare/capture value, pick compare or capture operation, choose what advances the counter and set a power-of-two prescaler. The counter can be paced by the system clock, by edges of a trigger input, by an event pulse, or by the overflow or underflow strobe of a neighbouring timer.

Four hardware conditions act on the channel: start, stop, clear and capture. Each has three independent enables that let it fire on a rising edge of the channel pin, a falling edge of that pin, or a condition event pulse. Software can also start and stop the channel directly. In compare mode the counter wraps after reaching the compare value. In capture mode it runs freely over the full range and latches its value on a capture condition. Sticky match and overflow flags drive a level interrupt through per-flag enables.

All inputs are assumed synchronous to `clk`.

Top module: `trig_cc_timer`

## Requirements
- R1: After reset the count and the compare/capture value are 0, the channel is stopped, both flags are 0 and `irq` is 0.
- R2: While running, the count advances once per 2^p selected source pulses, where p is the `cfg_psc` code (0 to 10). Codes 11 to 15 behave as 10. A count write or a clear restarts the prescaler.
- R3: In compare mode (`cfg_cap_mode`=0):
  - A tick taken when count equals the compare value loads 0 and sets `flag_ovf`.
  - Any tick whose resulting count equals the compare value sets `flag_match`.
- R4: `cfg_src` selects the count source:
  - 0: every clock
  - 1: rising edge of `trig_in`
  - 2: falling edge of `trig_in`
  - 3: `evt_cnt` pulse
  - 4: `peer_ovf` pulse
  - 5: `peer_udf` pulse
  - 6 and 7: nothing counts
- R5: Each hardware condition enable vector uses these bits:
  - bit0: rising edge of `chan_pin`
  - bit1: falling edge of `chan_pin`
  - bit2: `evt_cond` pulse

  A start condition makes the channel run from the next cycle. A stop condition halts it, and the count then holds. With all bits of a condition off, that condition never fires.
- R6: A clear condition sets the count to 0 on the next clock edge.
- R7: In capture mode (`cfg_cap_mode`=1):
  - A capture condition copies the current count into `cmp_cap` at the next edge.
  - The counter rolls from the maximum value to 0, setting `flag_ovf`.
- R8: A software start (`sw_start`) or stop (`sw_stop`) pulse acts like the hardware one. When start and stop fire in the same cycle, the channel ends up stopped.
- R9: Each flag stays set until its own clear pulse. A set in the same cycle as a clear wins.
- R10: `irq` is high while (`flag_match` and `ie_match`) or (`flag_ovf` and `ie_ovf`).
- R11: `cnt_wr` loads `cnt_wdata` into the count and takes priority over clear and counting. `cmp_wr` loads `cmp_wdata` into `cmp_cap`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cap_mode | input | 1 | 0 compare, 1 capture |
| cfg_src | input | 3 | Count source select (R4) |
| cfg_psc | input | 4 | Prescaler code |
| start_en | input | 3 | Start condition enables |
| stop_en | input | 3 | Stop condition enables |
| clr_en | input | 3 | Clear condition enables |
| cap_en | input | 3 | Capture condition enables |
| ie_match | input | 1 | Match interrupt enable |
| ie_ovf | input | 1 | Overflow interrupt enable |
| sw_start | input | 1 | Software start pulse |
| sw_stop | input | 1 | Software stop pulse |
| clr_match | input | 1 | Clear match flag pulse |
| clr_ovf | input | 1 | Clear overflow flag pulse |
| cnt_wr | input | 1 | Count write strobe |
| cnt_wdata | input | CNT_W | Count write value |
| cmp_wr | input | 1 | Compare write strobe |
| cmp_wdata | input | CNT_W | Compare write value |
| trig_in | input | 1 | Trigger input for edge counting |
| chan_pin | input | 1 | Channel pin for conditions |
| evt_cnt | input | 1 | Event pulse for counting |
| evt_cond | input | 1 | Event pulse for conditions |
| peer_ovf | input | 1 | Neighbour timer overflow strobe |
| peer_udf | input | 1 | Neighbour timer underflow strobe |
| running | output | 1 | Channel is counting |
| count | output | CNT_W | Current count |
| cmp_cap | output | CNT_W | Compare/capture value |
| flag_match | output | 1 | Sticky match flag |
| flag_ovf | output | 1 | Sticky overflow flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: a 16-bit counter and a prescaler code range of 0 to 10. The full 1024 division, including a clamped code of 11, is reached in about a thousand cycles. Rollover at 0xFFFF is reached without long waits by loading 0xFFFE through the count write port. A small compare value of 3 brings the compare wrap, the match flag and the overflow flag into a handful of cycles.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
  typedef enum logic [2:0] {
    SRC_SYSCLK = 3'd0,
    SRC_TRIG_R = 3'd1,
    SRC_TRIG_F = 3'd2,
    SRC_EVENT  = 3'd3,
    SRC_PEER_O = 3'd4,
    SRC_PEER_U = 3'd5
  } src_e;

  localparam int COND_N    = 4;
  localparam int COND_STA  = 0;
  localparam int COND_STP  = 1;
  localparam int COND_CLR  = 2;
  localparam int COND_CAP  = 3;
  localparam int EN_W      = 3;
endpackage

// File: rtl/tcc_cond_decode.sv
module tcc_cond_decode
  import tcc_pkg::*;
(
  input  logic [EN_W-1:0] en,
  input  logic            pin_rise,
  input  logic            pin_fall,
  input  logic            evt,
  output logic            fire
);
  always_comb begin
    fire = (en[0] & pin_rise) | (en[1] & pin_fall) | (en[2] & evt);
  end
endmodule

// File: rtl/tcc_prescaler.sv
module tcc_prescaler #(
  parameter int PSC_W   = 4,
  parameter int PSC_MAX = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             pulse,
  input  logic             restart,
  input  logic [PSC_W-1:0] code,
  output logic             tick
);
  localparam int DIV_W = (PSC_MAX > 0) ? PSC_MAX : 1;

  logic [DIV_W-1:0] div_q, div_d, limit;
  logic [PSC_W-1:0] eff;

  always_comb begin
    eff   = (int'(code) > PSC_MAX) ? PSC_W'(PSC_MAX) : code;
    limit = DIV_W'((1 << eff) - 1);
    tick  = run & pulse & (div_q >= limit);
    div_d = div_q;
    if (restart)           div_d = '0;
    else if (tick)         div_d = '0;
    else if (run && pulse) div_d = div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end
endmodule

// File: rtl/tcc_core.sv
module tcc_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clr,
  input  logic             cap,
  input  logic             cap_mode,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] cmp_wdata,
  input  logic             clr_match,
  input  logic             clr_ovf,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] cmp_cap,
  output logic             flag_match,
  output logic             flag_ovf
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_d, cmp_d, inc;
  logic             wrap, adv, ovf_set, match_set, fm_d, fo_d;

  always_comb begin
    wrap      = cap_mode ? (count == CNT_MAX) : (count == cmp_cap);
    inc       = wrap ? '0 : count + 1'b1;
    adv       = tick & ~cnt_wr & ~clr;
    ovf_set   = adv & wrap;
    match_set = adv & ~cap_mode & (inc == cmp_cap);
    cnt_d = count;
    if (cnt_wr)   cnt_d = cnt_wdata;
    else if (clr) cnt_d = '0;
    else if (adv) cnt_d = inc;
    cmp_d = cmp_cap;
    if (cap && cap_mode) cmp_d = count;
    else if (cmp_wr)     cmp_d = cmp_wdata;
    fm_d = match_set | (flag_match & ~clr_match);
    fo_d = ovf_set   | (flag_ovf   & ~clr_ovf);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count      <= '0;
      cmp_cap    <= '0;
      flag_match <= 1'b0;
      flag_ovf   <= 1'b0;
    end else begin
      count      <= cnt_d;
      cmp_cap    <= cmp_d;
      flag_match <= fm_d;
      flag_ovf   <= fo_d;
    end
  end

  // R6
  a_r6_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !cnt_wr) |=> (count == '0));
  // R3
  a_r3_cmp_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clr && !cnt_wr && !cap_mode && count == cmp_cap) |=> (count == '0 && flag_ovf));
  // R7
  a_r7_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (cap && cap_mode) |=> (cmp_cap == $past(count)));
  // R9
  a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_ovf && !clr_ovf) |=> flag_ovf);
endmodule

// File: rtl/trig_cc_timer.sv
module trig_cc_timer
  import tcc_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int PSC_W   = 4,
  parameter int PSC_MAX = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_cap_mode,
  input  logic [2:0]       cfg_src,
  input  logic [PSC_W-1:0] cfg_psc,
  input  logic [2:0]       start_en,
  input  logic [2:0]       stop_en,
  input  logic [2:0]       clr_en,
  input  logic [2:0]       cap_en,
  input  logic             ie_match,
  input  logic             ie_ovf,
  input  logic             sw_start,
  input  logic             sw_stop,
  input  logic             clr_match,
  input  logic             clr_ovf,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] cmp_wdata,
  input  logic             trig_in,
  input  logic             chan_pin,
  input  logic             evt_cnt,
  input  logic             evt_cond,
  input  logic             peer_ovf,
  input  logic             peer_udf,
  output logic             running,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] cmp_cap,
  output logic             flag_match,
  output logic             flag_ovf,
  output logic             irq
);
  logic trig_q, pin_q;
  logic trig_r, trig_f, pin_r, pin_f;
  logic src_pulse, tick, run_d, start_f, stop_f;
  logic [EN_W-1:0]   en_vec [COND_N];
  logic [COND_N-1:0] fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q  <= 1'b0;
      pin_q   <= 1'b0;
      running <= 1'b0;
    end else begin
      trig_q  <= trig_in;
      pin_q   <= chan_pin;
      running <= run_d;
    end
  end

  always_comb begin
    trig_r = trig_in & ~trig_q;
    trig_f = ~trig_in & trig_q;
    pin_r  = chan_pin & ~pin_q;
    pin_f  = ~chan_pin & pin_q;
    en_vec[COND_STA] = start_en;
    en_vec[COND_STP] = stop_en;
    en_vec[COND_CLR] = clr_en;
    en_vec[COND_CAP] = cap_en;
  end

  for (genvar g = 0; g < COND_N; g++) begin : g_cond
    tcc_cond_decode u_dec (
      .en       (en_vec[g]),
      .pin_rise (pin_r),
      .pin_fall (pin_f),
      .evt      (evt_cond),
      .fire     (fire[g])
    );
  end

  always_comb begin
    case (src_e'(cfg_src))
      SRC_SYSCLK: src_pulse = 1'b1;
      SRC_TRIG_R: src_pulse = trig_r;
      SRC_TRIG_F: src_pulse = trig_f;
      SRC_EVENT:  src_pulse = evt_cnt;
      SRC_PEER_O: src_pulse = peer_ovf;
      SRC_PEER_U: src_pulse = peer_udf;
      default:    src_pulse = 1'b0;
    endcase
    start_f = sw_start | fire[COND_STA];
    stop_f  = sw_stop  | fire[COND_STP];
    run_d   = running;
    if (stop_f)       run_d = 1'b0;
    else if (start_f) run_d = 1'b1;
    irq = (flag_match & ie_match) | (flag_ovf & ie_ovf);
  end

  tcc_prescaler #(.PSC_W(PSC_W), .PSC_MAX(PSC_MAX)) u_psc (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (running),
    .pulse   (src_pulse),
    .restart (cnt_wr | fire[COND_CLR]),
    .code    (cfg_psc),
    .tick    (tick)
  );

  tcc_core #(.CNT_W(CNT_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .clr        (fire[COND_CLR]),
    .cap        (fire[COND_CAP]),
    .cap_mode   (cfg_cap_mode),
    .cnt_wr     (cnt_wr),
    .cnt_wdata  (cnt_wdata),
    .cmp_wr     (cmp_wr),
    .cmp_wdata  (cmp_wdata),
    .clr_match  (clr_match),
    .clr_ovf    (clr_ovf),
    .count      (count),
    .cmp_cap    (cmp_cap),
    .flag_match (flag_match),
    .flag_ovf   (flag_ovf)
  );

  // R8
  a_r8_stop_wins: assert property (@(posedge clk) disable iff (!rst_n)
    stop_f |=> !running);
  // R5
  a_r5_start_runs: assert property (@(posedge clk) disable iff (!rst_n)
    (start_f && !stop_f) |=> running);
  // R5
  a_r5_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !cnt_wr && !fire[COND_CLR]) |=> $stable(count));
endmodule

// File: tb/trig_cc_timer_tb_top.sv
module trig_cc_timer_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_cap_mode = 0; logic [2:0] cfg_src = 0; logic [3:0] cfg_psc = 0;
  logic [2:0] start_en = 0, stop_en = 0, clr_en = 0, cap_en = 0;
  logic ie_match = 0, ie_ovf = 0, sw_start = 0, sw_stop = 0;
  logic clr_match = 0, clr_ovf = 0, cnt_wr = 0, cmp_wr = 0;
  logic [15:0] cnt_wdata = 0, cmp_wdata = 0;
  logic trig_in = 0, chan_pin = 0, evt_cnt = 0, evt_cond = 0;
  logic peer_ovf = 0, peer_udf = 0;
  logic running, flag_match, flag_ovf, irq;
  logic [15:0] count, cmp_cap;
  int n_chk = 0, n_fail = 0;
  logic [15:0] saved;

  always #5 clk = ~clk;

  trig_cc_timer dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_cap_mode(cfg_cap_mode), .cfg_src(cfg_src),
    .cfg_psc(cfg_psc), .start_en(start_en), .stop_en(stop_en), .clr_en(clr_en),
    .cap_en(cap_en), .ie_match(ie_match), .ie_ovf(ie_ovf), .sw_start(sw_start),
    .sw_stop(sw_stop), .clr_match(clr_match), .clr_ovf(clr_ovf), .cnt_wr(cnt_wr),
    .cnt_wdata(cnt_wdata), .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata), .trig_in(trig_in),
    .chan_pin(chan_pin), .evt_cnt(evt_cnt), .evt_cond(evt_cond), .peer_ovf(peer_ovf),
    .peer_udf(peer_udf), .running(running), .count(count), .cmp_cap(cmp_cap),
    .flag_match(flag_match), .flag_ovf(flag_ovf), .irq(irq));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic nxt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start(); sw_start = 1; nxt(1); sw_start = 0; endtask
  task automatic do_stop();  sw_stop = 1;  nxt(1); sw_stop = 0;  endtask
  task automatic wr_cnt(input logic [15:0] v);
    cnt_wdata = v; cnt_wr = 1; nxt(1); cnt_wr = 0;
  endtask
  task automatic wr_cmp(input logic [15:0] v);
    cmp_wdata = v; cmp_wr = 1; nxt(1); cmp_wr = 0;
  endtask
  task automatic pin_set(input logic v); chan_pin = v; nxt(1); endtask
  task automatic ev_cond(); evt_cond = 1; nxt(1); evt_cond = 0; endtask
  task automatic clr_flags(); clr_match = 1; clr_ovf = 1; nxt(1); clr_match = 0; clr_ovf = 0; endtask

  task automatic t_reset();
    chk("R1 count", count, 0);
    chk("R1 cmp", cmp_cap, 0);
    chk("R1 running", running, 0);
    chk("R1 flags", {flag_match, flag_ovf, irq}, 0);
  endtask

  task automatic t_sysclk();
    wr_cmp(16'd100);
    chk("R11 cmp write", cmp_cap, 16'd100);
    do_start();
    chk("R8 sw start", running, 1);
    nxt(5);
    chk("R4 sysclk count", count, 5);
    do_stop();
    nxt(3);
    chk("R8 sw stop hold", count, 6);
  endtask

  task automatic t_psc();
    wr_cnt(0); cfg_psc = 2;
    do_start(); nxt(8);
    chk("R2 div4", count, 2);
    do_stop(); wr_cnt(0); cfg_psc = 11;
    do_start(); nxt(1023);
    chk("R2 clamp before", count, 0);
    nxt(1);
    chk("R2 clamp after", count, 1);
    do_stop(); cfg_psc = 0;
  endtask

  task automatic t_src();
    wr_cnt(0); cfg_src = 1; do_start();
    repeat (3) begin trig_in = 1; nxt(1); trig_in = 0; nxt(1); end
    chk("R4 trig rise", count, 3);
    cfg_src = 2;
    repeat (3) begin trig_in = 1; nxt(1); trig_in = 0; nxt(1); end
    chk("R4 trig fall", count, 6);
    cfg_src = 3;
    repeat (2) begin evt_cnt = 1; nxt(1); evt_cnt = 0; nxt(1); end
    chk("R4 event", count, 8);
    cfg_src = 4; peer_ovf = 1; nxt(1); peer_ovf = 0; nxt(1);
    cfg_src = 5; peer_udf = 1; nxt(1); peer_udf = 0; nxt(1);
    chk("R4 peer", count, 10);
    cfg_src = 6; peer_ovf = 1; nxt(1); peer_ovf = 0; nxt(2);
    chk("R4 none", count, 10);
    do_stop(); cfg_src = 0;
  endtask

  task automatic t_cmp();
    wr_cmp(3); wr_cnt(0); clr_flags();
    do_start(); nxt(3);
    chk("R3 at match", {count, flag_match, flag_ovf}, {16'd3, 2'b10});
    nxt(1);
    chk("R3 wrap", {count, flag_ovf}, {16'd0, 1'b1});
    do_stop(); nxt(2);
    chk("R9 sticky", {flag_match, flag_ovf}, 2'b11);
    chk("R10 irq off", irq, 0);
    ie_ovf = 1; #1;
    chk("R10 irq ovf", irq, 1);
    clr_ovf = 1; nxt(1); clr_ovf = 0;
    chk("R9 clr ovf only", {flag_match, flag_ovf, irq}, 3'b100);
    ie_match = 1; #1;
    chk("R10 irq match", irq, 1);
    clr_match = 1; nxt(1); clr_match = 0;
    chk("R10 irq clear", irq, 0);
    ie_match = 0; ie_ovf = 0;
  endtask

  task automatic t_cond();
    start_en = 3'b001; stop_en = 3'b010;
    pin_set(1);
    chk("R5 hw start", running, 1);
    pin_set(0);
    chk("R5 hw stop", running, 0);
    saved = count;
    start_en = 0; stop_en = 0; clr_en = 0;
    pin_set(1); pin_set(0); ev_cond(); nxt(1);
    chk("R5 disabled", {running, count}, {1'b0, saved});
    clr_en = 3'b100; ev_cond();
    chk("R6 clear", count, 0);
    clr_en = 0; start_en = 3'b100; stop_en = 3'b100; ev_cond();
    chk("R8 hw stop wins", running, 0);
    start_en = 0; stop_en = 0;
    sw_start = 1; sw_stop = 1; nxt(1); sw_start = 0; sw_stop = 0;
    chk("R8 sw stop wins", running, 0);
  endtask

  task automatic t_cap();
    cfg_cap_mode = 1; cap_en = 3'b001;
    wr_cnt(16'h1234);
    pin_set(1);
    chk("R7 capture", cmp_cap, 16'h1234);
    pin_set(0); cap_en = 0; clr_flags();
    wr_cnt(16'hFFFE); do_start(); nxt(1);
    chk("R7 max", count, 16'hFFFF);
    nxt(1);
    chk("R7 roll", {count, flag_ovf, flag_match}, {16'd0, 2'b10});
    do_stop(); cfg_cap_mode = 0;
    clr_en = 3'b100; cnt_wdata = 16'h55; cnt_wr = 1; evt_cond = 1; nxt(1);
    cnt_wr = 0; evt_cond = 0; clr_en = 0;
    chk("R11 write over clear", count, 16'h55);
  endtask

  initial begin
    nxt(3); rst_n = 1; nxt(1);
    t_reset();
    t_sysclk();
    t_psc();
    t_src();
    t_cmp();
    t_cond();
    t_cap();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule